// File: doc/BRIEF.md
# Pulse-Swallow Synthesizer Divider Core

This block is the digital heart of a channel-selecting frequency synthesizer. It counts pulses from an external 32/33 dual-modulus prescaler and drives that prescaler's modulus control, so that the VCO side is divided by N = 32·M + A. It also divides the reference by 12 or 16, compares the two divided edges in a phase-frequency detector and turns the result into charge-pump commands: pump up, pump down or high impedance. A lock flag reports when the two divided edges have arrived close together for several comparisons in a row.

All logic runs on one fast sampling clock. The reference and prescaler outputs arrive as asynchronous levels, pass through synchronizers and are converted to single-cycle rising-edge events. The block has no data streams; every pin is a plain control or status level, so no valid/ready handshake or back-pressure applies. Configuration pins are sampled continuously; channel and reference ratio changes take effect at period boundaries.

Top module: `pss_synth_core`

## Requirements
- R1: The VCO-side divide ratio is N = 32·M + A, with M = 32 when `m_sel` is 0 and M = 34 when `m_sel` is 1; one modulus-control period spans exactly N prescaler input cycles, which for a 0.864 MHz comparison rate and a doubled carrier gives N·1.728 MHz (A=1, M=34 yields 1881.792 MHz; A=31, M=34 yields 1933.632 MHz).
- R2: `mod_ctl` is high (select divide-by-33) for the first A prescaler cycles of each period and low for the rest; A ranges 0 to 31, and A = 0 keeps `mod_ctl` low for the whole period.
- R3: A and M applied to the counter are captured only when a period ends; a change of `a_sel` in the middle of a period leaves that period unchanged and applies to the next one.
- R4: The reference divider divides by 16 when `ref_sel` is 1 and by 12 when `ref_sel` is 0.
- R5: With `pd_sense` = 0 the pump goes up while the divided VCO edge leads; with `pd_sense` = 1 it goes down in that case (and the reverse when the reference leads). A pump pulse lasts as many fast-clock cycles as the lead; edges in the same cycle give no pulse.
- R6: `pump_test` selects the pump mode, registered one cycle: 2'b00 high impedance, 2'b01 forced up, 2'b10 forced down, 2'b11 driven by the detector.
- R7: With `div_en` low or `flywheel` high the pump is high impedance whatever `pump_test` says; with `div_en` low the counters are held at a period start, `lock_o` is low and `mod_ctl` equals (`a_sel` != 0).
- R8: Exactly one of `pump_up`, `pump_dn`, `pump_hiz` is high at all times; after reset `pump_hiz` is high and `pump_up`, `pump_dn`, `mod_ctl`, `lock_o` are low.
- R9: `lock_o` rises after LOCK_COUNT consecutive comparisons whose lead is at most LOCK_TOL cycles, and falls as soon as a lead exceeds LOCK_TOL.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_in | input | 1 | Reference clock level |
| pre_in | input | 1 | Prescaler output level |
| a_sel | input | A_W | Swallow count A |
| m_sel | input | 1 | Main count select: 0 gives 32, 1 gives 34 |
| ref_sel | input | 1 | Reference ratio: 1 gives 16, 0 gives 12 |
| pd_sense | input | 1 | Detector polarity |
| pump_test | input | 2 | Pump mode select |
| div_en | input | 1 | Divider enable |
| flywheel | input | 1 | Hold pump in high impedance |
| mod_ctl | output | 1 | Prescaler modulus: 1 selects divide-by-33 |
| pump_up | output | 1 | Charge pump source on |
| pump_dn | output | 1 | Charge pump sink on |
| pump_hiz | output | 1 | Charge pump off |
| lock_o | output | 1 | Phase-lock indication |

## Verification
The bench builds the core with two synchronizer stages, a lock tolerance of two cycles and a lock count of four, so a lock decision takes about four comparison periods of roughly a thousand fast cycles and stays well inside the run. With one fast-clock cycle standing for one VCO cycle, whole divide periods of 1024 to 1119 cycles are measured directly, the two channel-table frequencies become exact integer checks, and phase offsets of two and five cycles fall on either side of the lock tolerance.

// File: rtl/pss_pkg.sv
package pss_pkg;
  // Charge-pump mode codes carried on pump_test
  typedef enum logic [1:0] {
    PT_HIZ = 2'b00,
    PT_UP  = 2'b01,
    PT_DN  = 2'b10,
    PT_RUN = 2'b11
  } pump_test_e;
endpackage

// File: rtl/pss_edge_sync.sv
module pss_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic rise
);
  localparam int SW = (STAGES < 2) ? 2 : STAGES;

  logic [SW-1:0] chain_q;
  logic          last_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
      last_q  <= 1'b0;
      rise    <= 1'b0;
    end else begin
      chain_q <= {chain_q[SW-2:0], din};
      last_q  <= chain_q[SW-1];
      rise    <= chain_q[SW-1] & ~last_q;
    end
  end
endmodule

// File: rtl/pss_ref_div.sv
module pss_ref_div #(
  parameter int DIV_LO = 12,
  parameter int DIV_HI = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic ref_rise,
  input  logic ref_sel,
  output logic fr_pulse
);
  localparam int DMAX = (DIV_HI > DIV_LO) ? DIV_HI : DIV_LO;
  localparam int CW   = $clog2(DMAX);

  logic [CW-1:0] cnt_q, term_q, term_new;

  assign term_new = ref_sel ? CW'(DIV_HI - 1) : CW'(DIV_LO - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      term_q   <= CW'(DIV_HI - 1);
      fr_pulse <= 1'b0;
    end else if (!run) begin
      cnt_q    <= '0;
      term_q   <= term_new;
      fr_pulse <= 1'b0;
    end else begin
      fr_pulse <= 1'b0;
      if (ref_rise) begin
        if (cnt_q == term_q) begin
          cnt_q    <= '0;
          term_q   <= term_new;
          fr_pulse <= 1'b1;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/pss_swallow_ctl.sv
module pss_swallow_ctl #(
  parameter int A_W  = 5,
  parameter int M_LO = 32,
  parameter int M_HI = 34
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           run,
  input  logic           pre_rise,
  input  logic [A_W-1:0] a_cfg,
  input  logic           m_cfg,
  output logic           fv_pulse,
  output logic           mod_ctl
);
  localparam int MMAX = (M_HI > M_LO) ? M_HI : M_LO;
  localparam int MW   = $clog2(MMAX);

  logic [MW-1:0]  idx_q, idx_n, mterm_q, mterm_new;
  logic [A_W-1:0] a_q, a_n;
  logic           wrap;

  assign mterm_new = m_cfg ? MW'(M_HI - 1) : MW'(M_LO - 1);

  always_comb begin
    wrap  = (idx_q == mterm_q);
    idx_n = wrap ? '0 : idx_q + 1'b1;
    a_n   = wrap ? a_cfg : a_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q    <= '0;
      a_q      <= '0;
      mterm_q  <= MW'(M_LO - 1);
      fv_pulse <= 1'b0;
      mod_ctl  <= 1'b0;
    end else if (!run) begin
      idx_q    <= '0;
      a_q      <= a_cfg;
      mterm_q  <= mterm_new;
      fv_pulse <= 1'b0;
      mod_ctl  <= (a_cfg != '0);
    end else begin
      fv_pulse <= 1'b0;
      if (pre_rise) begin
        idx_q    <= idx_n;
        fv_pulse <= wrap;
        mod_ctl  <= (idx_n < MW'(a_n));
        if (wrap) begin
          a_q     <= a_cfg;
          mterm_q <= mterm_new;
        end
      end
    end
  end
endmodule

// File: rtl/pss_phase_det.sv
module pss_phase_det #(
  parameter int LOCK_TOL   = 2,
  parameter int LOCK_COUNT = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic fr_pulse,
  input  logic fv_pulse,
  output logic ref_lead,
  output logic vco_lead,
  output logic lock_o
);
  localparam int WW = $clog2(LOCK_TOL + 2);
  localparam int SW = $clog2(LOCK_COUNT + 2);

  logic          r_q, v_q, both;
  logic [WW-1:0] wcnt_q;
  logic [SW-1:0] streak_q;
  logic          over_q;

  assign both     = r_q & v_q;
  assign ref_lead = r_q & ~v_q;
  assign vco_lead = v_q & ~r_q;

  // Dual-flop detector, both flops cleared once both are set
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      r_q <= 1'b0;
      v_q <= 1'b0;
    end else if (!run) begin
      r_q <= 1'b0;
      v_q <= 1'b0;
    end else begin
      r_q <= (r_q & ~both) | fr_pulse;
      v_q <= (v_q & ~both) | fv_pulse;
    end
  end

  // Lead-width measurement and lock qualification
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wcnt_q   <= '0;
      streak_q <= '0;
      over_q   <= 1'b0;
      lock_o   <= 1'b0;
    end else if (!run) begin
      wcnt_q   <= '0;
      streak_q <= '0;
      over_q   <= 1'b0;
      lock_o   <= 1'b0;
    end else if (both) begin
      wcnt_q <= '0;
      over_q <= 1'b0;
      if (!over_q) begin
        if (streak_q != SW'(LOCK_COUNT)) streak_q <= streak_q + 1'b1;
        if (streak_q >= SW'(LOCK_COUNT - 1)) lock_o <= 1'b1;
      end
    end else if (r_q ^ v_q) begin
      if (wcnt_q == WW'(LOCK_TOL)) begin
        over_q   <= 1'b1;
        streak_q <= '0;
        lock_o   <= 1'b0;
      end else begin
        wcnt_q <= wcnt_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/pss_synth_core.sv
module pss_synth_core
  import pss_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int A_W         = 5,
  parameter int M_LO        = 32,
  parameter int M_HI        = 34,
  parameter int REF_DIV_LO  = 12,
  parameter int REF_DIV_HI  = 16,
  parameter int LOCK_TOL    = 2,
  parameter int LOCK_COUNT  = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           ref_in,
  input  logic           pre_in,
  input  logic [A_W-1:0] a_sel,
  input  logic           m_sel,
  input  logic           ref_sel,
  input  logic           pd_sense,
  input  logic [1:0]     pump_test,
  input  logic           div_en,
  input  logic           flywheel,
  output logic           mod_ctl,
  output logic           pump_up,
  output logic           pump_dn,
  output logic           pump_hiz,
  output logic           lock_o
);
  localparam int N_IN = 2;

  logic [N_IN-1:0] raw_in, rise_ev;
  logic            fr_pulse, fv_pulse;
  logic            ref_lead, vco_lead;
  logic            up_d, dn_d;
  pump_test_e      mode;

  assign raw_in = {pre_in, ref_in};

  for (genvar gi = 0; gi < N_IN; gi++) begin : g_sync
    pss_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .din  (raw_in[gi]),
      .rise (rise_ev[gi])
    );
  end

  pss_ref_div #(.DIV_LO(REF_DIV_LO), .DIV_HI(REF_DIV_HI)) u_ref_div (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (div_en),
    .ref_rise(rise_ev[0]),
    .ref_sel (ref_sel),
    .fr_pulse(fr_pulse)
  );

  pss_swallow_ctl #(.A_W(A_W), .M_LO(M_LO), .M_HI(M_HI)) u_swallow (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (div_en),
    .pre_rise(rise_ev[1]),
    .a_cfg   (a_sel),
    .m_cfg   (m_sel),
    .fv_pulse(fv_pulse),
    .mod_ctl (mod_ctl)
  );

  pss_phase_det #(.LOCK_TOL(LOCK_TOL), .LOCK_COUNT(LOCK_COUNT)) u_pd (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (div_en),
    .fr_pulse(fr_pulse),
    .fv_pulse(fv_pulse),
    .ref_lead(ref_lead),
    .vco_lead(vco_lead),
    .lock_o  (lock_o)
  );

  assign mode = pump_test_e'(pump_test);

  always_comb begin
    up_d = 1'b0;
    dn_d = 1'b0;
    if (div_en && !flywheel) begin
      unique case (mode)
        PT_UP:  up_d = 1'b1;
        PT_DN:  dn_d = 1'b1;
        PT_RUN: begin
          up_d = pd_sense ? ref_lead : vco_lead;
          dn_d = pd_sense ? vco_lead : ref_lead;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pump_up  <= 1'b0;
      pump_dn  <= 1'b0;
      pump_hiz <= 1'b1;
    end else begin
      pump_up  <= up_d;
      pump_dn  <= dn_d;
      pump_hiz <= ~(up_d | dn_d);
    end
  end
endmodule

// File: rtl/pss_synth_core_chk.sv
module pss_synth_core_chk #(
  parameter int A_W = 5
) (
  input logic           clk,
  input logic           rst_n,
  input logic [A_W-1:0] a_sel,
  input logic           pd_sense,
  input logic [1:0]     pump_test,
  input logic           div_en,
  input logic           flywheel,
  input logic           mod_ctl,
  input logic           pump_up,
  input logic           pump_dn,
  input logic           pump_hiz,
  input logic           lock_o,
  input logic           vco_lead
);
  p_pump_onehot_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot({pump_up, pump_dn, pump_hiz}));

  p_off_hiz_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!div_en || flywheel) |=> pump_hiz);

  p_idle_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !div_en |=> (mod_ctl == ($past(a_sel) != '0)) && !lock_o);

  p_force_up_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (div_en && !flywheel && pump_test == 2'b01) |=> pump_up);

  p_force_dn_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (div_en && !flywheel && pump_test == 2'b10) |=> pump_dn);

  p_sense_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (div_en && !flywheel && pump_test == 2'b11 && vco_lead)
      |=> (pd_sense ? pump_dn : pump_up) || !$past(div_en));
endmodule

bind pss_synth_core pss_synth_core_chk #(.A_W(A_W)) u_chk (.*);

// File: tb/pss_synth_core_tb.sv
module pss_synth_core_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ref_in, pre_in;
  logic [4:0] a_sel = 5'd0;
  logic       m_sel = 1'b0, ref_sel = 1'b1, pd_sense = 1'b0;
  logic [1:0] pump_test = 2'b11;
  logic       div_en = 1'b0, flywheel = 1'b0;
  logic       mod_ctl, pump_up, pump_dn, pump_hiz, lock_o;

  int checks = 0;
  int errors = 0;
  int oh_bad = 0;
  int ref_per = 0;
  int ref_dly = 0;
  int tick, pc, plen;

  always #4 clk = ~clk;

  pss_synth_core u_dut (
    .clk(clk), .rst_n(rst_n), .ref_in(ref_in), .pre_in(pre_in),
    .a_sel(a_sel), .m_sel(m_sel), .ref_sel(ref_sel), .pd_sense(pd_sense),
    .pump_test(pump_test), .div_en(div_en), .flywheel(flywheel),
    .mod_ctl(mod_ctl), .pump_up(pump_up), .pump_dn(pump_dn),
    .pump_hiz(pump_hiz), .lock_o(lock_o)
  );

  // VCO = one tick per fast clock; 32/33 prescaler and reference source
  always @(negedge clk) begin
    if (!rst_n || !div_en) begin
      tick <= 0; pc <= 0; plen <= 32; pre_in <= 1'b0; ref_in <= 1'b0;
    end else begin
      pre_in <= (pc == plen - 1);
      if (pc == 8) plen <= mod_ctl ? 33 : 32;
      pc <= (pc == plen - 1) ? 0 : pc + 1;
      ref_in <= (ref_per != 0) && (tick >= ref_dly) &&
                (((tick - ref_dly + 1) % ref_per) == 0);
      tick <= tick + 1;
    end
  end

  always @(negedge clk)
    if (rst_n && !$onehot({pump_up, pump_dn, pump_hiz})) oh_bad <= oh_bad + 1;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic drive_at_posedge();
    @(posedge clk); #1;
  endtask

  task automatic wait_mod_rise();
    logic prev;
    prev = mod_ctl;
    forever begin
      @(negedge clk);
      if (mod_ctl && !prev) break;
      prev = mod_ctl;
    end
  endtask

  // Starts at a rise: returns high cycles and rise-to-rise cycles
  task automatic meas_period(output int hi, output int per);
    logic prev;
    wait_mod_rise();
    hi = 1; per = 1; prev = 1'b1;
    forever begin
      @(negedge clk);
      if (mod_ctl && !prev) break;
      per++;
      if (mod_ctl) hi++;
      prev = mod_ctl;
    end
  endtask

  task automatic observe(input int cyc, output int upc, output int upn,
                         output int dnc, output int dnn);
    logic pu, pd;
    upc = 0; upn = 0; dnc = 0; dnn = 0; pu = 1'b0; pd = 1'b0;
    for (int i = 0; i < cyc; i++) begin
      @(negedge clk);
      if (pump_up) upc++;
      if (pump_dn) dnc++;
      if (pump_up && !pu) upn++;
      if (pump_dn && !pd) dnn++;
      pu = pump_up; pd = pump_dn;
    end
  endtask

  task automatic start_pfd(input int a, input logic m, input logic rs,
                           input logic sense, input int per, input int dly);
    drive_at_posedge();
    div_en = 1'b0;
    repeat (4) @(posedge clk);
    #1;
    a_sel = 5'(a); m_sel = m; ref_sel = rs; pd_sense = sense;
    pump_test = 2'b11; ref_per = per; ref_dly = dly;
    repeat (2) @(posedge clk);
    #1;
    div_en = 1'b1;
  endtask

  // a, m_sel, expected carrier kHz
  localparam int VEC [5][3] = '{
    '{1, 1, 1881792}, '{31, 1, 1933632}, '{10, 1, 1897344},
    '{5, 0, 1778112}, '{31, 0, 1823040}
  };

  initial begin
    repeat (190000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int hi, per, nexp, upc, upn, dnc, dnn, cnt;
    logic prev;
    repeat (3) @(negedge clk);
    // R8 reset state
    check(pump_hiz && !pump_up && !pump_dn && !mod_ctl && !lock_o, "R8 reset",
          {pump_hiz, pump_up, pump_dn, mod_ctl, lock_o}, 5'b10000);
    drive_at_posedge();
    rst_n = 1'b1;
    ref_per = 0;
    drive_at_posedge();
    div_en = 1'b1;

    // R1/R2 table of channel settings
    for (int v = 0; v < 5; v++) begin
      drive_at_posedge();
      a_sel = 5'(VEC[v][0]); m_sel = VEC[v][1][0];
      wait_mod_rise();
      meas_period(hi, per);
      nexp = 32 * (VEC[v][1] != 0 ? 34 : 32) + VEC[v][0];
      check(per == nexp, "R1 divide ratio", per, nexp);
      check(per * 1728 == VEC[v][2], "R1 carrier kHz", per * 1728, VEC[v][2]);
      check(hi == 33 * VEC[v][0], "R2 modulus high cycles", hi, 33 * VEC[v][0]);
    end

    // R2 A=0: modulus stays low
    drive_at_posedge();
    a_sel = 5'd0; m_sel = 1'b0;
    repeat (1200) @(negedge clk);
    cnt = 0;
    for (int i = 0; i < 1100; i++) begin
      @(negedge clk);
      if (mod_ctl) cnt++;
    end
    check(cnt == 0, "R2 A=0 modulus low", cnt, 0);

    // R3 mid-period change
    drive_at_posedge();
    a_sel = 5'd20;
    wait_mod_rise();
    wait_mod_rise();
    hi = 1; prev = 1'b1;
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk);
      if (i == 50) a_sel = 5'd4;
      if (!mod_ctl) break;
      hi++;
    end
    check(hi == 660, "R3 current period keeps old A", hi, 660);
    meas_period(hi, per);
    check(hi == 132, "R3 next period uses new A", hi, 132);
    check(per == 1028, "R3 next period ratio", per, 1028);

    // R4/R5/R9 aligned, divide-by-12 reference
    start_pfd(8, 1'b0, 1'b0, 1'b0, 86, 0);
    observe(8000, upc, upn, dnc, dnn);
    check(upc == 0 && dnc == 0, "R5 dead zone", upc + dnc, 0);
    check(lock_o == 1'b1, "R4 R9 lock with ref/12", lock_o, 1);

    // R9 lock loss after phase step
    drive_at_posedge();
    ref_dly = 6;
    repeat (3000) @(negedge clk);
    check(lock_o == 1'b0, "R9 lock lost", lock_o, 0);

    // R5 vco leads by 2, sense 0
    start_pfd(8, 1'b0, 1'b0, 1'b0, 86, 2);
    observe(8000, upc, upn, dnc, dnn);
    check(upn > 0 && upc == 2 * upn, "R5 up width sense0", upn > 0 ? upc / upn : 0, 2);
    check(dnc == 0, "R5 no down sense0", dnc, 0);
    check(lock_o == 1'b1, "R9 lock within tolerance", lock_o, 1);

    // R5 sense 1
    start_pfd(8, 1'b0, 1'b0, 1'b1, 86, 2);
    observe(6000, upc, upn, dnc, dnn);
    check(dnn > 0 && dnc == 2 * dnn, "R5 down width sense1", dnn > 0 ? dnc / dnn : 0, 2);
    check(upc == 0, "R5 no up sense1", upc, 0);

    // R9 lead beyond tolerance
    start_pfd(8, 1'b0, 1'b0, 1'b0, 86, 5);
    observe(8000, upc, upn, dnc, dnn);
    check(upn > 0 && upc == 5 * upn, "R5 up width 5", upn > 0 ? upc / upn : 0, 5);
    check(lock_o == 1'b0, "R9 no lock beyond tolerance", lock_o, 0);

    // R4 divide-by-16 with same source: vco faster
    start_pfd(8, 1'b0, 1'b1, 1'b0, 86, 0);
    observe(8000, upc, upn, dnc, dnn);
    check(upc > 0 && dnc == 0, "R4 R5 ref/16 slower gives up only", dnc, 0);
    check(lock_o == 1'b0, "R4 ref/16 mismatch no lock", lock_o, 0);

    // R4 divide-by-16 matched
    start_pfd(0, 1'b0, 1'b1, 1'b0, 64, 0);
    observe(8000, upc, upn, dnc, dnn);
    check(lock_o == 1'b1 && upc == 0 && dnc == 0, "R4 lock with ref/16", lock_o, 1);

    // R6 test modes
    drive_at_posedge(); pump_test = 2'b01;
    repeat (2) @(negedge clk);
    check(pump_up && !pump_dn && !pump_hiz, "R6 forced up", {pump_up, pump_dn, pump_hiz}, 3'b100);
    drive_at_posedge(); pump_test = 2'b10;
    repeat (2) @(negedge clk);
    check(pump_dn && !pump_up && !pump_hiz, "R6 forced down", {pump_up, pump_dn, pump_hiz}, 3'b010);
    drive_at_posedge(); pump_test = 2'b00;
    repeat (2) @(negedge clk);
    check(pump_hiz && !pump_up && !pump_dn, "R6 tristate", {pump_up, pump_dn, pump_hiz}, 3'b001);

    // R7 flywheel and disable override
    drive_at_posedge(); pump_test = 2'b01; flywheel = 1'b1;
    repeat (2) @(negedge clk);
    check(pump_hiz && !pump_up, "R7 flywheel hiz", {pump_up, pump_dn, pump_hiz}, 3'b001);
    drive_at_posedge(); flywheel = 1'b0; div_en = 1'b0; a_sel = 5'd8;
    repeat (3) @(negedge clk);
    check(pump_hiz && !pump_up, "R7 disabled hiz", {pump_up, pump_dn, pump_hiz}, 3'b001);
    check(!lock_o && mod_ctl, "R7 disabled lock/modulus", {lock_o, mod_ctl}, 2'b01);

    check(oh_bad == 0, "R8 one-hot pump", oh_bad, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule